// File: doc/BRIEF.md
# Video Display Processor Bus Glue

This block sits between a 6502-style processor bus and a two-register video display processor, and also hands out chip enables for a bank of other peripherals. It compares the CPU address against a two-byte window. When a cycle in the second clock phase hits that window, the block pulls low either an active-low read strobe or an active-low write strobe toward the video chip, depending on the R/W line. Address line A0 goes straight to the chip's register-select input, so the two bytes of the window reach its two internal ports.

The video chip numbers its data pins in the opposite order to the CPU: its pin 0 carries the most significant bit. The block mirrors the byte in both directions. Write data passes through a register toward the chip. Read data from the chip is mirrored and placed on the CPU bus only while the read strobe is active. A separate decoder splits a 2 KiB region of high memory into eight 256-byte pages and drives one active-low enable per page.

All decode results are registered on the block's clock. Every output therefore reflects the bus inputs sampled at the previous rising edge. Both base addresses are compile-time parameters (defaults: window at 0xC010/0xC011, page region 0xE000 to 0xE7FF).

Top module: `vdpBusGlue`

## Requirements
- R1: While reset is low, vdpReadN, vdpWriteN and every pageSelN bit are 1, and vdpDataOe, cpuDataOe, vdpModeSel, vdpDataOut and cpuDataOut are 0.
- R2: One clock after a sample with cpuPhi2=1, cpuRw=1 and cpuAddr equal to VDP_BASE or VDP_BASE+1, vdpReadN is 0. vdpReadN is 1 after any other sample.
- R3: One clock after a sample with cpuPhi2=1, cpuRw=0 and cpuAddr in the window, vdpWriteN is 0. vdpWriteN is 1 after any other sample.
- R4: A sample with cpuPhi2=0 (first phase) produces no strobe, whatever the address and R/W.
- R5: An address one below or two above VDP_BASE, or anywhere else outside the window, produces no strobe.
- R6: vdpModeSel equals cpuAddr bit 0 from the previous sample.
- R7: vdpDataOut bit i equals cpuDataIn bit 7-i from the previous sample, and vdpDataOe is 1 exactly when vdpWriteN is 0.
- R8: cpuDataOe is 1 exactly when vdpReadN is 0. cpuDataOut bit i then equals vdpDataIn bit 7-i of the current cycle, and cpuDataOut is 0 at all other times.
- R9: One clock after a sample with cpuAddr in PAGE_BASE to PAGE_BASE+0x7FF, pageSelN bit k is 0, where k is cpuAddr bits 10:8. The page enables do not depend on cpuPhi2 or cpuRw.
- R10: One clock after a sample outside the page region, every pageSelN bit is 1. At no time is more than one pageSelN bit 0.
- R11: A sample taken while reset is low produces no strobe, even when it matches the window in the second phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus |
| cpuRw | input | 1 | CPU R/W, 1 = read |
| cpuPhi2 | input | 1 | CPU second clock phase, 1 = Phi2 |
| cpuDataIn | input | 8 | Data driven by the CPU |
| cpuDataOut | output | 8 | Read data toward the CPU, mirrored |
| cpuDataOe | output | 1 | Drive enable for cpuDataOut |
| vdpDataIn | input | 8 | Data driven by the video chip, MSB on bit 0 |
| vdpDataOut | output | 8 | Write data toward the video chip, MSB on bit 0 |
| vdpDataOe | output | 1 | Drive enable for vdpDataOut |
| vdpModeSel | output | 1 | Register select of the video chip (from A0) |
| vdpReadN | output | 1 | Active-low read strobe |
| vdpWriteN | output | 1 | Active-low write strobe |
| pageSelN | output | 8 | Active-low enables, one per 256-byte page |

## Verification
The hardest condition to reach is a sample that matches the window in the second phase while reset is still held. A purely random bench never produces it, because reset is released before any traffic starts. The stimulus therefore drives a matching read and a matching write during the reset period and checks that no strobe follows. Random traffic is also biased, so that about a third of the addresses fall in the two-byte window and a third in the page region. Directed cases cover the addresses next to the edges of the window and of the region.

// File: rtl/vdpGluePkg.sv
package vdpGluePkg;

  // Registered decode results handed from control to datapath
  typedef struct packed {
    logic rd;       // read cycle to the video chip
    logic wr;       // write cycle to the video chip
    logic modeSel;  // sampled A0
    logic pageHit;  // address inside the page region
  } glueStrobes_t;

  function automatic logic [7:0] mirrorByte(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/vdpGlueCtrl.sv
module vdpGlueCtrl
  import vdpGluePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [15:0] VDP_BASE = 16'hC010,
  parameter logic [15:0] PAGE_BASE = 16'hE000,
  parameter int PAGES = 8,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic                      cpuRw,
  input  logic                      cpuPhi2,
  output glueStrobes_t              stbQ,
  output logic [$clog2(PAGES)-1:0]  pageIdxQ
);
  localparam int SEL_W = $clog2(PAGES);
  localparam int REGION_LO = PAGE_SHIFT + SEL_W;

  logic winHit;
  logic regionHit;
  glueStrobes_t stbD;

  assign winHit    = (cpuAddr[ADDR_W-1:1] == VDP_BASE[ADDR_W-1:1]);
  assign regionHit = (cpuAddr[ADDR_W-1:REGION_LO] == PAGE_BASE[ADDR_W-1:REGION_LO]);

  always_comb begin
    stbD.rd      = rstN && cpuPhi2 && cpuRw && winHit;
    stbD.wr      = rstN && cpuPhi2 && !cpuRw && winHit;
    stbD.modeSel = cpuAddr[0];
    stbD.pageHit = regionHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ     <= '0;
      pageIdxQ <= '0;
    end else begin
      stbQ     <= stbD;
      pageIdxQ <= cpuAddr[PAGE_SHIFT +: SEL_W];
    end
  end

  // R2
  rd_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbQ.rd |-> ($past(cpuPhi2) && $past(cpuRw) && $past(winHit)));

  // R3
  wr_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbQ.wr |-> ($past(cpuPhi2) && !$past(cpuRw) && $past(winHit)));

endmodule

// File: rtl/vdpGlueData.sv
module vdpGlueData
  import vdpGluePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  glueStrobes_t              stb,
  input  logic [$clog2(PAGES)-1:0]  pageIdx,
  input  logic [DATA_W-1:0]         cpuDataIn,
  input  logic [DATA_W-1:0]         vdpDataIn,
  output logic [DATA_W-1:0]         cpuDataOut,
  output logic                      cpuDataOe,
  output logic [DATA_W-1:0]         vdpDataOut,
  output logic                      vdpDataOe,
  output logic                      vdpModeSel,
  output logic                      vdpReadN,
  output logic                      vdpWriteN,
  output logic [PAGES-1:0]          pageSelN
);
  localparam int SEL_W = $clog2(PAGES);

  logic [DATA_W-1:0] wrMirror;
  logic [DATA_W-1:0] rdMirror;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign wrMirror[i] = cpuDataIn[DATA_W-1-i];
    assign rdMirror[i] = vdpDataIn[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vdpDataOut <= '0;
    else       vdpDataOut <= wrMirror;
  end

  for (genvar k = 0; k < PAGES; k++) begin : g_page
    assign pageSelN[k] = !(stb.pageHit && (pageIdx == SEL_W'(k)));
  end

  assign vdpReadN   = !stb.rd;
  assign vdpWriteN  = !stb.wr;
  assign vdpModeSel = stb.modeSel;
  assign vdpDataOe  = stb.wr;
  assign cpuDataOe  = stb.rd;
  assign cpuDataOut = stb.rd ? rdMirror : '0;

  // R10
  page_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~pageSelN));

  // R2 R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!vdpReadN && !vdpWriteN));

  // R7 R8
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDataOe |-> !vdpDataOe);

endmodule

// File: rtl/vdpBusGlue.sv
module vdpBusGlue
  import vdpGluePkg::*;
#(
  parameter logic [15:0] VDP_BASE = 16'hC010,
  parameter logic [15:0] PAGE_BASE = 16'hE000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRw,
  input  logic        cpuPhi2,
  input  logic [7:0]  cpuDataIn,
  output logic [7:0]  cpuDataOut,
  output logic        cpuDataOe,
  input  logic [7:0]  vdpDataIn,
  output logic [7:0]  vdpDataOut,
  output logic        vdpDataOe,
  output logic        vdpModeSel,
  output logic        vdpReadN,
  output logic        vdpWriteN,
  output logic [7:0]  pageSelN
);
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGES = 8;
  localparam int SEL_W = $clog2(PAGES);

  glueStrobes_t stb;
  logic [SEL_W-1:0] pageIdx;

  vdpGlueCtrl #(
    .ADDR_W(ADDR_W), .VDP_BASE(VDP_BASE), .PAGE_BASE(PAGE_BASE),
    .PAGES(PAGES), .PAGE_SHIFT(8)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRw(cpuRw),
    .cpuPhi2(cpuPhi2), .stbQ(stb), .pageIdxQ(pageIdx)
  );

  vdpGlueData #(.DATA_W(DATA_W), .PAGES(PAGES)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .pageIdx(pageIdx),
    .cpuDataIn(cpuDataIn), .vdpDataIn(vdpDataIn),
    .cpuDataOut(cpuDataOut), .cpuDataOe(cpuDataOe),
    .vdpDataOut(vdpDataOut), .vdpDataOe(vdpDataOe),
    .vdpModeSel(vdpModeSel), .vdpReadN(vdpReadN),
    .vdpWriteN(vdpWriteN), .pageSelN(pageSelN)
  );

endmodule

// File: tb/test_vdpBusGlue.sv
module test_vdpBusGlue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRw = 1'b1, cpuPhi2 = 1'b0;
  logic [7:0] cpuDataIn = '0, vdpDataIn = '0;
  logic [7:0] cpuDataOut, vdpDataOut, pageSelN;
  logic cpuDataOe, vdpDataOe, vdpModeSel, vdpReadN, vdpWriteN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expectations for the next sample point
  logic eRd, eWr, eMode;
  logic [7:0] eVdpData, ePage;

  always #4 clk = ~clk;

  vdpBusGlue i_vdpBusGlue (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRw(cpuRw),
    .cpuPhi2(cpuPhi2), .cpuDataIn(cpuDataIn), .cpuDataOut(cpuDataOut),
    .cpuDataOe(cpuDataOe), .vdpDataIn(vdpDataIn), .vdpDataOut(vdpDataOut),
    .vdpDataOe(vdpDataOe), .vdpModeSel(vdpModeSel), .vdpReadN(vdpReadN),
    .vdpWriteN(vdpWriteN), .pageSelN(pageSelN)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compute expected outputs from the inputs just driven
  task automatic predict();
    logic win, reg_;
    win  = (cpuAddr[15:1] == 15'(16'hC010 >> 1));
    reg_ = (cpuAddr[15:11] == 5'b11100);
    if (!rstN) begin
      eRd = 0; eWr = 0; eMode = 0; eVdpData = 0; ePage = 8'hFF;
    end else begin
      eRd = cpuPhi2 && cpuRw && win;
      eWr = cpuPhi2 && !cpuRw && win;
      eMode = cpuAddr[0];
      eVdpData = rev8(cpuDataIn);
      ePage = reg_ ? ~(8'h01 << cpuAddr[10:8]) : 8'hFF;
    end
  endtask

  task automatic checkOutputs();
    chk("R2 read strobe", {7'd0, vdpReadN}, {7'd0, !eRd});
    chk("R3 write strobe", {7'd0, vdpWriteN}, {7'd0, !eWr});
    chk("R6 mode select", {7'd0, vdpModeSel}, {7'd0, eMode});
    chk("R7 write data mirror", vdpDataOut, eVdpData);
    chk("R7 write drive enable", {7'd0, vdpDataOe}, {7'd0, eWr});
    chk("R8 read drive enable", {7'd0, cpuDataOe}, {7'd0, eRd});
    chk("R8 read data mirror", cpuDataOut, eRd ? rev8(vdpDataIn) : 8'h00);
    chk("R9 R10 page enables", pageSelN, ePage);
  endtask

  task automatic step(input logic [15:0] a, input logic rw, input logic p2,
                      input logic [7:0] cd, input logic [7:0] vd);
    @(negedge clk);
    checkOutputs();
    cpuAddr = a; cpuRw = rw; cpuPhi2 = p2; cpuDataIn = cd; vdpDataIn = vd;
    predict();
  endtask

  initial begin
    logic [15:0] a;
    int sel;
    void'($urandom(32'd1234));
    predict();
    // R1 / R11: matching cycles during reset give no strobe
    step(16'hC010, 1'b1, 1'b1, 8'hA5, 8'h3C);
    step(16'hC011, 1'b0, 1'b1, 8'h5A, 8'h3C);
    step(16'hE300, 1'b1, 1'b1, 8'h12, 8'h00);
    @(negedge clk);
    chk("R1 reset readN", {7'd0, vdpReadN}, 8'h01);
    chk("R11 reset writeN", {7'd0, vdpWriteN}, 8'h01);
    chk("R1 reset pages", pageSelN, 8'hFF);
    rstN = 1'b1;
    predict();
    // directed corners
    step(16'hC010, 1'b1, 1'b1, 8'h00, 8'h01); // R2 base, R8 mirror
    step(16'hC011, 1'b1, 1'b1, 8'h00, 8'h80); // R2 base+1, R6
    step(16'hC011, 1'b0, 1'b1, 8'h01, 8'h00); // R3, R7 0x01 -> 0x80
    step(16'hC010, 1'b0, 1'b0, 8'hF0, 8'h00); // R4 phi1
    step(16'hC011, 1'b1, 1'b0, 8'h0F, 8'hFF); // R4 phi1 read
    step(16'hC00F, 1'b1, 1'b1, 8'h00, 8'hFF); // R5 below
    step(16'hC012, 1'b0, 1'b1, 8'h00, 8'hFF); // R5 above
    step(16'hE000, 1'b1, 1'b0, 8'h00, 8'h00); // R9 first page, phi1
    step(16'hE7FF, 1'b0, 1'b1, 8'h00, 8'h00); // R9 last page
    step(16'hE800, 1'b1, 1'b1, 8'h00, 8'h00); // R10 above region
    step(16'hDFFF, 1'b1, 1'b1, 8'h00, 8'h00); // R10 below region
    for (int n = 0; n < 3000; n++) begin
      sel = $urandom_range(0, 2);
      a = 16'($urandom);
      if (sel == 0) a = {15'(16'hC010 >> 1), a[0]};
      else if (sel == 1) a = {5'b11100, a[10:0]};
      step(a, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end
    step(16'h0000, 1'b1, 1'b0, 8'h00, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule